// File: doc/BRIEF.md
# Vectored System-Call Entry and Return Sequencer

This block carries out the two halves of a vectored system call. When the call operation is presented and its facility enable is set, it stores the return address and the current machine state into the link/count register pair. It does this with a single write to a special-register RAM, whose two halves sit at one shared index. It then sends the fetch unit to one of 128 entry vectors, and the new machine state is privileged, untranslated and 64-bit. When the enable is clear, no state is touched and a facility-unavailable pulse is raised instead.

The return operation reads the same RAM index once. The restored address and state arrive one cycle after the read. The block then redirects fetch to that address and restores the privilege, translation and width bits. Only one operation is in flight at a time. Requests that arrive while an operation is under way are dropped.

Top module: `vsc_seq`

## Requirements
- R1: An accepted call (call request with `fac_en`=1) raises `spr_we` for exactly one cycle, in the cycle after the request is sampled. `spr_idx` is the link/count slot, `spr_wr_even` is (call address + 4) with bits 1:0 cleared, and `spr_wr_odd` is `cur_state`, zero-extended.
- R2: One cycle after the write, `redir_valid` pulses for one cycle. During that pulse `redir_priv`=1, `redir_xlate`=0 and `redir_wide`=1.
- R3: The entry address is 0x17000 + level×0x20 for the 7-bit level. Level 0 gives 0x17000 and level 127 gives 0x17FE0.
- R4: A call request with `fac_en`=0 pulses `fac_trap` in the next cycle. It causes no RAM write and no redirect, and the link/count contents stay unchanged, as a later return shows.
- R5: An accepted return raises `spr_re` for one cycle, in the cycle after the request is sampled, at the link/count slot.
- R6: Two cycles after the read request, `redir_valid` pulses. `redir_addr` is the even (link) data with bits 1:0 cleared. `redir_priv`, `redir_xlate` and `redir_wide` are odd (count) data bits 0, 1 and 2.
- R7: A request sampled while an operation is in progress is ignored. No extra write, read, trap or redirect follows from it.
- R8: While reset is high and right after it, `spr_we`, `spr_re`, `redir_valid` and `fac_trap` are 0.
- R9: If call and return are requested in the same cycle, the call is taken and the return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sc_req | input | 1 | Vectored call request |
| rf_req | input | 1 | Vectored return request |
| sc_pc | input | AW | Address of the call instruction |
| sc_lvl | input | LVL_W | Entry level selecting the vector |
| cur_state | input | ST_W | Current machine state to save |
| fac_en | input | 1 | Facility enable for the call |
| spr_idx | output | IDX_W | Special-register RAM index |
| spr_we | output | 1 | RAM write strobe (both halves) |
| spr_re | output | 1 | RAM read strobe |
| spr_wr_even | output | AW | Write data, even half (link) |
| spr_wr_odd | output | AW | Write data, odd half (count) |
| spr_rd_even | input | AW | Read data, even half, valid one cycle after `spr_re` |
| spr_rd_odd | input | AW | Read data, odd half, valid one cycle after `spr_re` |
| redir_valid | output | 1 | One-cycle fetch redirect strobe |
| redir_addr | output | AW | Redirect target |
| redir_priv | output | 1 | New privileged bit |
| redir_xlate | output | 1 | New translation bit |
| redir_wide | output | 1 | New 64-bit mode bit |
| fac_trap | output | 1 | Facility-unavailable pulse |

## Verification
Take N as the cycle in which a request is sampled. The write strobe, the read strobe and the trap pulse are due at N+1. The entry redirect is due at N+2, and the return redirect at N+3, because the RAM takes one cycle to answer. The driver task computes each expected item with its due cycle and pushes it onto a queue. The monitor samples on the falling clock edge and compares the items due in that cycle. Any strobe that rises with no item due is reported as unexpected, so dropped requests and priority losers are caught as well.

// File: rtl/vsc_pkg.sv
package vsc_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_SAVE  = 2'd1,
    SQ_FETCH = 2'd2,
    SQ_WAIT  = 2'd3
  } seq_st_e;

  localparam int unsigned ST_PRIV_POS  = 0;
  localparam int unsigned ST_XLATE_POS = 1;
  localparam int unsigned ST_WIDE_POS  = 2;
endpackage

// File: rtl/vsc_vector.sv
module vsc_vector #(
  parameter int unsigned AW        = 64,
  parameter int unsigned LVL_W     = 7,
  parameter int unsigned STRIDE_LG = 5,
  parameter logic [AW-1:0] BASE    = 'h17000
) (
  input  logic [LVL_W-1:0] lvl,
  output logic [AW-1:0]    vec
);
  localparam int unsigned PAD = AW - LVL_W;

  logic [AW-1:0] lvl_ext;

  assign lvl_ext = {{PAD{1'b0}}, lvl};
  assign vec     = BASE + (lvl_ext << STRIDE_LG);
endmodule

// File: rtl/vsc_fsm.sv
module vsc_fsm
  import vsc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    call_req,
  input  logic    ret_req,
  input  logic    fac_en,
  output seq_st_e st,
  output logic    take_call,
  output logic    take_ret,
  output logic    deny_call
);
  logic idle;

  assign idle      = (st == SQ_IDLE);
  assign take_call = idle && call_req && fac_en;
  assign deny_call = idle && call_req && !fac_en;
  assign take_ret  = idle && ret_req && !call_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= SQ_IDLE;
    end else begin
      unique case (st)
        SQ_IDLE: begin
          if (take_call)     st <= SQ_SAVE;
          else if (take_ret) st <= SQ_FETCH;
        end
        SQ_SAVE:  st <= SQ_IDLE;
        SQ_FETCH: st <= SQ_WAIT;
        SQ_WAIT:  st <= SQ_IDLE;
        default:  st <= SQ_IDLE;
      endcase
    end
  end

  // R7: the sequencer leaves idle only through an accepted operation
  p_leave_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (st == SQ_IDLE && !take_call && !take_ret) |=> (st == SQ_IDLE));
endmodule

// File: rtl/vsc_restore.sv
module vsc_restore
  import vsc_pkg::*;
#(
  parameter int unsigned AW = 64
) (
  input  logic [AW-1:0] rd_even,
  input  logic [AW-1:0] rd_odd,
  output logic [AW-1:0] tgt,
  output logic          priv,
  output logic          xlate,
  output logic          wide
);
  assign tgt   = {rd_even[AW-1:2], 2'b00};
  assign priv  = rd_odd[ST_PRIV_POS];
  assign xlate = rd_odd[ST_XLATE_POS];
  assign wide  = rd_odd[ST_WIDE_POS];
endmodule

// File: rtl/vsc_seq.sv
module vsc_seq
  import vsc_pkg::*;
#(
  parameter int unsigned AW        = 64,
  parameter int unsigned LVL_W     = 7,
  parameter int unsigned ST_W      = 16,
  parameter int unsigned IDX_W     = 4,
  parameter int unsigned SLOT      = 1,
  parameter int unsigned STRIDE_LG = 5,
  parameter logic [AW-1:0] BASE    = 'h17000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sc_req,
  input  logic             rf_req,
  input  logic [AW-1:0]    sc_pc,
  input  logic [LVL_W-1:0] sc_lvl,
  input  logic [ST_W-1:0]  cur_state,
  input  logic             fac_en,
  output logic [IDX_W-1:0] spr_idx,
  output logic             spr_we,
  output logic             spr_re,
  output logic [AW-1:0]    spr_wr_even,
  output logic [AW-1:0]    spr_wr_odd,
  input  logic [AW-1:0]    spr_rd_even,
  input  logic [AW-1:0]    spr_rd_odd,
  output logic             redir_valid,
  output logic [AW-1:0]    redir_addr,
  output logic             redir_priv,
  output logic             redir_xlate,
  output logic             redir_wide,
  output logic             fac_trap
);
  localparam int unsigned ST_PAD = AW - ST_W;
  localparam logic [AW-1:0] INSN_BYTES = 'd4;
  localparam logic [AW-1:0] VEC_LAST = BASE + ({{(AW-LVL_W){1'b0}}, {LVL_W{1'b1}}} << STRIDE_LG);

  seq_st_e       st;
  logic          take_call, take_ret, deny_call;
  logic [AW-1:0] vec, vec_q;
  logic [AW-1:0] ret_pc;
  logic [AW-1:0] rs_tgt;
  logic          rs_priv, rs_xlate, rs_wide;

  vsc_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .call_req  (sc_req),
    .ret_req   (rf_req),
    .fac_en    (fac_en),
    .st        (st),
    .take_call (take_call),
    .take_ret  (take_ret),
    .deny_call (deny_call)
  );

  vsc_vector #(
    .AW(AW), .LVL_W(LVL_W), .STRIDE_LG(STRIDE_LG), .BASE(BASE)
  ) u_vec (
    .lvl (sc_lvl),
    .vec (vec)
  );

  vsc_restore #(.AW(AW)) u_rs (
    .rd_even (spr_rd_even),
    .rd_odd  (spr_rd_odd),
    .tgt     (rs_tgt),
    .priv    (rs_priv),
    .xlate   (rs_xlate),
    .wide    (rs_wide)
  );

  assign spr_idx = IDX_W'(SLOT);
  assign ret_pc  = sc_pc + INSN_BYTES;

  always_ff @(posedge clk) begin
    if (rst) begin
      spr_we      <= 1'b0;
      spr_re      <= 1'b0;
      fac_trap    <= 1'b0;
      spr_wr_even <= '0;
      spr_wr_odd  <= '0;
      vec_q       <= '0;
      redir_valid <= 1'b0;
      redir_addr  <= '0;
      redir_priv  <= 1'b0;
      redir_xlate <= 1'b0;
      redir_wide  <= 1'b0;
    end else begin
      spr_we      <= take_call;
      spr_re      <= take_ret;
      fac_trap    <= deny_call;
      redir_valid <= 1'b0;
      if (take_call) begin
        spr_wr_even <= {ret_pc[AW-1:2], 2'b00};
        spr_wr_odd  <= {{ST_PAD{1'b0}}, cur_state};
        vec_q       <= vec;
      end
      if (st == SQ_SAVE) begin
        redir_valid <= 1'b1;
        redir_addr  <= vec_q;
        redir_priv  <= 1'b1;
        redir_xlate <= 1'b0;
        redir_wide  <= 1'b1;
      end else if (st == SQ_WAIT) begin
        redir_valid <= 1'b1;
        redir_addr  <= rs_tgt;
        redir_priv  <= rs_priv;
        redir_xlate <= rs_xlate;
        redir_wide  <= rs_wide;
      end
    end
  end

  p_save_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    spr_we |=> !spr_we);

  p_entry_follows_save_r2: assert property (@(posedge clk) disable iff (rst)
    spr_we |=> (redir_valid && redir_priv && !redir_xlate && redir_wide));

  p_redir_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    redir_valid |=> !redir_valid);

  p_entry_range_r3: assert property (@(posedge clk) disable iff (rst)
    spr_we |=> (redir_addr >= BASE && redir_addr <= VEC_LAST));

  p_trap_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    fac_trap |-> (!spr_we && !spr_re && !redir_valid));

  p_read_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    spr_re |=> !spr_re);

  p_return_timing_r6: assert property (@(posedge clk) disable iff (rst)
    spr_re |=> !redir_valid ##1 redir_valid);

  p_redir_aligned_r6: assert property (@(posedge clk) disable iff (rst)
    redir_valid |-> (redir_addr[1:0] == 2'b00));

  p_single_op_r7: assert property (@(posedge clk) disable iff (rst)
    !(spr_we && spr_re));

  p_reset_quiet_r8: assert property (@(posedge clk)
    $past(rst) |-> (!spr_we && !spr_re && !redir_valid && !fac_trap));
endmodule

// File: tb/tb_vsc_seq.sv
module tb_vsc_seq;
  localparam int AW = 64, LVL_W = 7, ST_W = 16, IDX_W = 4, SLOT = 1;

  logic clk = 1'b0, rst = 1'b1;
  logic sc_req = 0, rf_req = 0, fac_en = 0;
  logic [AW-1:0] sc_pc = '0;
  logic [LVL_W-1:0] sc_lvl = '0;
  logic [ST_W-1:0] cur_state = '0;
  logic [IDX_W-1:0] spr_idx;
  logic spr_we, spr_re, redir_valid, redir_priv, redir_xlate, redir_wide, fac_trap;
  logic [AW-1:0] spr_wr_even, spr_wr_odd, redir_addr;
  logic [AW-1:0] spr_rd_even = '0, spr_rd_odd = '0;

  always #10 clk = ~clk;

  vsc_seq dut (
    .clk(clk), .rst(rst), .sc_req(sc_req), .rf_req(rf_req), .sc_pc(sc_pc),
    .sc_lvl(sc_lvl), .cur_state(cur_state), .fac_en(fac_en), .spr_idx(spr_idx),
    .spr_we(spr_we), .spr_re(spr_re), .spr_wr_even(spr_wr_even),
    .spr_wr_odd(spr_wr_odd), .spr_rd_even(spr_rd_even), .spr_rd_odd(spr_rd_odd),
    .redir_valid(redir_valid), .redir_addr(redir_addr), .redir_priv(redir_priv),
    .redir_xlate(redir_xlate), .redir_wide(redir_wide), .fac_trap(fac_trap)
  );

  // RAM model with a bench-side preload port
  logic [AW-1:0] ram_e [2**IDX_W];
  logic [AW-1:0] ram_o [2**IDX_W];
  logic poke = 0;
  logic [AW-1:0] poke_e = '0, poke_o = '0;
  always @(posedge clk) begin
    if (poke) begin
      ram_e[SLOT] <= poke_e;
      ram_o[SLOT] <= poke_o;
    end else if (spr_we) begin
      ram_e[spr_idx] <= spr_wr_even;
      ram_o[spr_idx] <= spr_wr_odd;
    end
    if (spr_re) begin
      spr_rd_even <= ram_e[spr_idx];
      spr_rd_odd  <= ram_o[spr_idx];
    end
  end

  typedef struct {
    int due; int kind; logic [AW-1:0] a; logic [AW-1:0] b; logic [2:0] f; string req;
  } exp_t;
  localparam int K_WR = 0, K_RD = 1, K_RDIR = 2, K_FU = 3;

  exp_t q[$];
  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;
  logic [AW-1:0] m_e = '0, m_o = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(int due, int kind, logic [AW-1:0] a, logic [AW-1:0] b,
                      logic [2:0] f, string req);
    exp_t e;
    e.due = due; e.kind = kind; e.a = a; e.b = b; e.f = f; e.req = req;
    q.push_back(e);
  endtask

  task automatic fail(string req, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    errors++;
    $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      bit seen [4];
      for (int k = 0; k < 4; k++) seen[k] = 0;
      while (q.size() > 0 && q[0].due <= cyc) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (e.due < cyc) fail(e.req, "missed event", 0, 1);
        else begin
          seen[e.kind] = 1;
          case (e.kind)
            K_WR: begin
              if (!spr_we) fail(e.req, "spr_we", spr_we, 1);
              else if (spr_idx != IDX_W'(SLOT)) fail(e.req, "spr_idx", spr_idx, SLOT);
              else if (spr_wr_even != e.a) fail(e.req, "even data", spr_wr_even, e.a);
              else if (spr_wr_odd != e.b) fail(e.req, "odd data", spr_wr_odd, e.b);
            end
            K_RD: begin
              if (!spr_re) fail(e.req, "spr_re", spr_re, 1);
              else if (spr_idx != IDX_W'(SLOT)) fail(e.req, "spr_idx", spr_idx, SLOT);
            end
            K_RDIR: begin
              if (!redir_valid) fail(e.req, "redir_valid", redir_valid, 1);
              else if (redir_addr != e.a) fail(e.req, "redir_addr", redir_addr, e.a);
              else if ({redir_wide, redir_xlate, redir_priv} != e.f)
                fail(e.req, "state bits", {redir_wide, redir_xlate, redir_priv}, e.f);
            end
            default: if (!fac_trap) fail(e.req, "fac_trap", fac_trap, 1);
          endcase
        end
      end
      if (spr_we && !seen[K_WR]) begin checks++; fail("R7", "unexpected spr_we", 1, 0); end
      if (spr_re && !seen[K_RD]) begin checks++; fail("R7", "unexpected spr_re", 1, 0); end
      if (redir_valid && !seen[K_RDIR]) begin checks++; fail("R7", "unexpected redirect", 1, 0); end
      if (fac_trap && !seen[K_FU]) begin checks++; fail("R4", "unexpected fac_trap", 1, 0); end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // call request held for `hold` cycles; also_ret asserts the return request too (R9)
  task automatic call_op(logic [AW-1:0] pc, logic [LVL_W-1:0] lvl, logic [ST_W-1:0] st,
                         bit en, int hold, bit also_ret, string req);
    int n;
    @(negedge clk);
    n = cyc;
    sc_req = 1; rf_req = also_ret; sc_pc = pc; sc_lvl = lvl; cur_state = st; fac_en = en;
    if (en) begin
      push(n + 1, K_WR, (pc + 64'd4) & ~64'd3, {48'd0, st}, 3'b000, req);
      push(n + 2, K_RDIR, 64'h17000 + 64'(lvl) * 64'h20, 64'd0, 3'b101, req);
      m_e = (pc + 64'd4) & ~64'd3;
      m_o = {48'd0, st};
    end else begin
      push(n + 1, K_FU, 64'd0, 64'd0, 3'b000, req);
    end
    idle(hold);
    sc_req = 0; rf_req = 0; fac_en = 0;
    idle(4);
  endtask

  task automatic ret_op(int hold, string req);
    int n;
    @(negedge clk);
    n = cyc;
    rf_req = 1;
    push(n + 1, K_RD, 64'd0, 64'd0, 3'b000, req);
    push(n + 3, K_RDIR, m_e & ~64'd3, 64'd0, {m_o[2], m_o[1], m_o[0]}, req);
    idle(hold);
    rf_req = 0;
    idle(4);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    idle(3);
    // R8: quiet outputs in reset
    checks++;
    if (spr_we || spr_re || redir_valid || fac_trap)
      fail("R8", "outputs in reset", {spr_we, spr_re, redir_valid, fac_trap}, 0);
    rst = 0;
    idle(1);
    checks++;
    if (spr_we || spr_re || redir_valid || fac_trap)
      fail("R8", "outputs after reset", {spr_we, spr_re, redir_valid, fac_trap}, 0);

    // R1 R2 R3: level 0 entry at base
    call_op(64'h1000, 7'd0, 16'h00A5, 1, 1, 0, "R1/R2/R3 lvl0");
    // R5 R6: return restores
    ret_op(1, "R5/R6 return");
    // R3: top level and unaligned return address
    call_op(64'hFFFF_0000_0000_1233, 7'd127, 16'h0002, 1, 1, 0, "R1/R3 lvl127");
    ret_op(1, "R6 after lvl127");
    // R4: disabled call leaves LR/CTR untouched
    call_op(64'h5550, 7'd5, 16'hFFFF, 0, 1, 0, "R4 disabled");
    ret_op(1, "R4 state kept");
    // R7: held requests taken once
    call_op(64'h2000, 7'd3, 16'h0004, 1, 2, 0, "R7 held call");
    ret_op(3, "R7 held return");
    // R9: simultaneous call and return
    call_op(64'h3000, 7'd64, 16'h0001, 1, 1, 1, "R9 call wins");
    // R6: low bits of restored link value are cleared
    @(negedge clk);
    poke = 1; poke_e = 64'h0000_0000_ABCD_4003; poke_o = 64'h6;
    @(negedge clk);
    poke = 0; m_e = 64'h0000_0000_ABCD_4003; m_o = 64'h6;
    ret_op(1, "R6 low bits cleared");
    // R3: a spread of levels
    for (int l = 1; l < 128; l += 37)
      call_op(64'h4000 + 64'(l) * 8, 7'(l), 16'(l), 1, 1, 0, "R3 level sweep");
    idle(6);
    checks++;
    if (q.size() != 0) fail("R2", "pending expectations", q.size(), 0);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule